// File: doc/BRIEF.md
# Second-Order Multi-Level Delta-Sigma Truncator

This block reduces a 14-bit unsigned control word to one of 15 output levels (0 to 14), one level per sampling clock, while pushing the truncation error to high frequencies with a second-order noise transfer function (1 - z^-1)^2. A slow analog filter after the current array then recovers the fine value: the long-run average of the level tracks the input scaled by 14/2^14.

The modulator is built as an error-feedback loop. It scales the input word by 14, adds twice the previous remainder, and subtracts the remainder from two samples back. It keeps the integer part, in units of 2^14, as the level and stores the fractional remainder for the next samples. The level is clamped to 0..14. The level and a 15-bit thermometer vector are registered together. The thermometer vector switches on exactly `level` of 15 matched unit current sources, lowest index first. An enable input parks the block at level 0 with a cleared error history.

Top module: `ds15_truncator`

## Requirements
- R1: While `rst` is high at a rising clock edge, both remainder registers are cleared and `level_out` and `therm_out` become 0. The first enabled sample after reset therefore sees a zero error history.
- R2: When `enable` is low at a rising edge, the next `level_out` and `therm_out` are 0 and both remainder registers are cleared. After `enable` returns high, the modulator restarts from a zero history.
- R3: At each enabled rising edge, with input x and stored remainders e1 (previous) and e2 (two back), the block forms u = 14*x + 2*e1 - e2. It registers level = floor(u / 2^14), clamped per R4, and stores the new remainder e = u - level*2^14, saturated to the range -32768..32767. The output appears right after that edge.
- R4: The level is clamped below at 0 and above at 14. The block never outputs a value outside 0..14, even for x = 16383 or after a drop from full scale to 0.
- R5: `therm_out` bit i is 1 exactly when i < `level_out`, so the number of set bits equals the level and the set bits are contiguous from bit 0.
- R6: For a constant input x held for 8192 enabled samples from a cleared history, the sum of levels times 2^14 differs from 8192*14*x by no more than 8192*14. That is, the average lies within one input LSB of x*14/2^14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run modulator; low parks output at 0 and clears history |
| acc_word | input | 14 | Unsigned control word to be truncated |
| level_out | output | 4 | Registered output level, 0..14 |
| therm_out | output | 15 | Registered thermometer vector for the unit current array |

## Verification
On every cycle the assertions check that the level stays within 0..14 and that the thermometer vector has exactly `level_out` set bits, packed from bit 0. They also check that a disabled cycle is followed by a zero output and that an unclamped remainder lies in [0, 2^14). The exact level sequence can only be shown by the bench scenarios, which compare each cycle against a behavioural model under constant, full-scale, zero, ramping and scrambled inputs. The same holds for the restart from a cleared history after reset or disable, and for the long-run average of the noise-shaped output.

// File: rtl/ds15_pkg.sv
package ds15_pkg;

    localparam int DEF_IN_W   = 14;
    localparam int DEF_LEVELS = 15;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_LOW  = 2'd1,
        CLAMP_HIGH = 2'd2
    } clamp_e;

    // Saturate a signed value into [lo, hi]
    function automatic logic signed [31:0] sat32(
        input logic signed [31:0] v,
        input logic signed [31:0] lo,
        input logic signed [31:0] hi
    );
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/ds15_err_shaper.sv
module ds15_err_shaper #(
    parameter int IN_W = 14,
    parameter int STEP = 14,
    parameter int EW   = 17,
    parameter int SW   = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [IN_W-1:0]      acc_word,
    input  logic signed [EW-1:0] err_new,
    output logic signed [SW-1:0] shaped
);
    logic signed [EW-1:0] err_d1;
    logic signed [EW-1:0] err_d2;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            err_d1 <= '0;
            err_d2 <= '0;
        end else begin
            err_d2 <= err_d1;
            err_d1 <= err_new;
        end
    end

    logic signed [SW-1:0] scaled_in;
    logic signed [SW-1:0] e1_ext;
    logic signed [SW-1:0] e2_ext;

    always_comb begin
        scaled_in = SW'($signed({1'b0, acc_word}) * STEP);
        e1_ext    = SW'(err_d1);
        e2_ext    = SW'(err_d2);
        shaped    = scaled_in + (e1_ext <<< 1) - e2_ext;
    end

endmodule

// File: rtl/ds15_quantizer.sv
module ds15_quantizer
    import ds15_pkg::*;
#(
    parameter int IN_W   = 14,
    parameter int LEVELS = 15,
    parameter int LVL_W  = 4,
    parameter int EW     = 17,
    parameter int SW     = 20
) (
    input  logic signed [SW-1:0] shaped,
    output logic [LVL_W-1:0]     level,
    output logic signed [EW-1:0] err,
    output clamp_e               clamp_kind
);
    localparam int ERR_LIM = 1 << (IN_W + 1);
    localparam int TOP_LVL = LEVELS - 1;

    logic signed [SW-1:0] whole;
    logic signed [31:0]   resid;
    logic [LVL_W-1:0]     lvl_c;

    always_comb begin
        whole = shaped >>> IN_W;
        if (whole < 0) begin
            lvl_c      = '0;
            clamp_kind = CLAMP_LOW;
        end else if (whole > SW'(TOP_LVL)) begin
            lvl_c      = LVL_W'(TOP_LVL);
            clamp_kind = CLAMP_HIGH;
        end else begin
            lvl_c      = LVL_W'(whole);
            clamp_kind = CLAMP_NONE;
        end
        resid = 32'(shaped) - (32'(lvl_c) <<< IN_W);
        err   = EW'(sat32(resid, -ERR_LIM, ERR_LIM - 1));
        level = lvl_c;
    end

endmodule

// File: rtl/ds15_therm_out.sv
module ds15_therm_out #(
    parameter int LEVELS = 15,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LVL_W-1:0]  level_d,
    output logic [LVL_W-1:0]  level_q,
    output logic [LEVELS-1:0] therm_q
);
    logic [LEVELS-1:0] therm_d;

    genvar gi;
    generate
        for (gi = 0; gi < LEVELS; gi++) begin : g_unit
            assign therm_d[gi] = (level_d > LVL_W'(gi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            level_q <= '0;
            therm_q <= '0;
        end else begin
            level_q <= level_d;
            therm_q <= therm_d;
        end
    end

endmodule

// File: rtl/ds15_truncator.sv
module ds15_truncator
    import ds15_pkg::*;
#(
    parameter int IN_W   = DEF_IN_W,
    parameter int LEVELS = DEF_LEVELS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [IN_W-1:0]   acc_word,
    output logic [$clog2(LEVELS)-1:0] level_out,
    output logic [LEVELS-1:0] therm_out
);
    localparam int LVL_W = $clog2(LEVELS);
    localparam int STEP  = LEVELS - 1;
    localparam int EW    = IN_W + 3;
    localparam int SW    = IN_W + 6;

    logic signed [SW-1:0] shaped;
    logic signed [EW-1:0] err_new;
    logic [LVL_W-1:0]     level_d;
    clamp_e               clamp_kind;

    ds15_err_shaper #(.IN_W(IN_W), .STEP(STEP), .EW(EW), .SW(SW)) u_shaper (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .acc_word (acc_word),
        .err_new  (err_new),
        .shaped   (shaped)
    );

    ds15_quantizer #(.IN_W(IN_W), .LEVELS(LEVELS), .LVL_W(LVL_W), .EW(EW), .SW(SW)) u_quant (
        .shaped     (shaped),
        .level      (level_d),
        .err        (err_new),
        .clamp_kind (clamp_kind)
    );

    ds15_therm_out #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_therm (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .level_d (level_d),
        .level_q (level_out),
        .therm_q (therm_out)
    );

    assert_level_range_R4: assert property (@(posedge clk) disable iff (rst)
        level_out <= LVL_W'(LEVELS - 1));

    assert_therm_count_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(therm_out) == int'(level_out));

    assert_therm_contig_R5: assert property (@(posedge clk) disable iff (rst)
        ((({1'b0, therm_out}) + 1'b1) & {1'b0, therm_out}) == '0);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (level_out == '0 && therm_out == '0));

    assert_resid_span_R3: assert property (@(posedge clk) disable iff (rst)
        (enable && clamp_kind == CLAMP_NONE) |->
            (err_new >= 0 && err_new < EW'(1 << IN_W)));

endmodule

// File: tb/sim_ds15_truncator.sv
`timescale 1ns/1ps
module sim_ds15_truncator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [13:0] acc_word = '0;
    logic [3:0]  level_out;
    logic [14:0] therm_out;

    int total = 0;
    int bad = 0;
    int m_e1 = 0;
    int m_e2 = 0;
    int exp_lvl = 0;
    longint lvl_sum = 0;
    int seen_top = 0;

    always #10 clk = ~clk;

    ds15_truncator u0 (
        .clk(clk), .rst(rst), .enable(enable), .acc_word(acc_word),
        .level_out(level_out), .therm_out(therm_out)
    );

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // behavioural model step for inputs seen at the last edge
    task automatic model_step(input bit r, input bit en, input int x);
        int u, q, e;
        if (r || !en) begin
            exp_lvl = 0; m_e1 = 0; m_e2 = 0;
        end else begin
            u = 14 * x + 2 * m_e1 - m_e2;
            q = u >>> 14;
            if (q < 0) q = 0;
            if (q > 14) q = 14;
            e = u - q * 16384;
            if (e < -32768) e = -32768;
            if (e > 32767) e = 32767;
            m_e2 = m_e1; m_e1 = e; exp_lvl = q;
        end
    endtask

    task automatic cycle(input bit en, input int x, input string tag);
        logic [14:0] exp_th;
        enable = en; acc_word = 14'(x);
        @(posedge clk);
        model_step(rst, en, x);
        @(negedge clk);
        exp_th = 15'((32'd1 << exp_lvl) - 1);
        total++;
        if (int'(level_out) != exp_lvl) begin
            bad++;
            $display("FAIL %s level: actual=%0d expected=%0d", tag, level_out, exp_lvl);
        end
        total++;
        if (therm_out != exp_th) begin
            bad++;
            $display("FAIL R5 therm: actual=%b expected=%b", therm_out, exp_th);
        end
        lvl_sum += longint'(level_out);
        if (level_out == 4'd14) seen_top++;
    endtask

    task automatic avg_run(input int x);
        longint diff;
        lvl_sum = 0;
        for (int i = 0; i < 8192; i++) cycle(1'b1, x, "R3");
        diff = lvl_sum * 16384 - longint'(8192) * 14 * x;
        if (diff < 0) diff = -diff;
        total++;
        if (diff > longint'(8192) * 14) begin
            bad++;
            $display("FAIL R6 average x=%0d: actual_sum=%0d expected_sum_x16384=%0d",
                     x, lvl_sum, longint'(8192) * 14 * x);
        end
    endtask

    initial begin
        int x;
        @(negedge clk);
        rst = 1'b1;
        cycle(1'b1, 9000, "R1");
        cycle(1'b1, 9000, "R1");
        total++;
        if (level_out != 0 || therm_out != 0) begin
            bad++;
            $display("FAIL R1 reset outputs: actual=%0d/%b expected=0/0", level_out, therm_out);
        end
        rst = 1'b0;
        // R1: first sample from cleared history: 14*8192/16384 = 7
        cycle(1'b1, 8192, "R1");
        total++;
        if (level_out != 4'd7) begin
            bad++;
            $display("FAIL R1 first sample: actual=%0d expected=7", level_out);
        end
        // R6 averages from cleared history
        cycle(1'b0, 0, "R2");
        avg_run(8192);
        cycle(1'b0, 0, "R2");
        avg_run(5000);
        cycle(1'b0, 0, "R2");
        avg_run(1234);
        // R4 high clamp at full scale
        seen_top = 0;
        for (int i = 0; i < 300; i++) cycle(1'b1, 16383, "R4");
        total++;
        if (seen_top == 0) begin
            bad++;
            $display("FAIL R4 full scale: actual=no level 14 expected=level 14 seen");
        end
        // R4 low clamp after drop to zero
        for (int i = 0; i < 100; i++) cycle(1'b1, 0, "R4");
        // R3 ramp and scrambled patterns
        for (int i = 0; i < 2000; i++) cycle(1'b1, (i * 37) % 16384, "R3");
        x = 123;
        for (int i = 0; i < 3000; i++) begin
            x = (x * 75 + 74) % 65537;
            cycle(1'b1, x % 16384, "R3");
        end
        // R2 disable mid-run, then restart from cleared history
        cycle(1'b0, 12000, "R2");
        total++;
        if (level_out != 0 || therm_out != 0) begin
            bad++;
            $display("FAIL R2 disabled: actual=%0d/%b expected=0/0", level_out, therm_out);
        end
        cycle(1'b1, 8192, "R2");
        total++;
        if (level_out != 4'd7) begin
            bad++;
            $display("FAIL R2 restart: actual=%0d expected=7", level_out);
        end
        for (int i = 0; i < 50; i++) cycle(1'b1, 16383 - i * 100, "R3");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule